// File: doc/BRIEF.md
# Voltage Regulator Start-up Sequencer

This block walks the reference code of a regulator's DAC through power-up. It stays idle until the supply reports power-on-reset clear and the enable request is high. It then waits a fixed start delay and ramps the DAC code one LSB per slew tick. Each LSB is 5 mV. The ticks come from the system clock: one tick per `TICK_CYC` cycles gives 5 mV/µs, and one tick per two of those gives 2.5 mV/µs.

An external window comparator reports once per PWM cycle whether the output is inside its band. After `WIN_N` consecutive in-band PWM strobes, the active-low clock enable is driven low. Power-good follows once a long delay, counted from ramp start, has run out. Power-good never rises while the clock enable is still high.

In CPU mode the first ramp goes at the slow rate to a fixed boot code. The move to the commanded VID code only starts at the fast rate once the clock enable is low. In GPU mode there is no boot stage: the first ramp goes at the fast rate straight to the commanded code.

Top module: `vr_startup_seq`

## Requirements
- R1: Out of reset, and from the clock edge after `en_req` or `por_ok` is sampled low, `dac_code` is 0, `clk_en_n` is 1 and `pgood` is 0. This holds at any point of the sequence.
- R2: The first DAC step appears `START_DLY + P` clock edges after the first edge at which `en_req` and `por_ok` are both high. P is the step period of the first stage: `2*TICK_CYC` in CPU mode and `TICK_CYC` in GPU mode.
- R3: With `gpu_mode` = 0, the first stage raises `dac_code` by exactly 1 every `2*TICK_CYC` cycles until it equals `BOOT_CODE`, then holds it. `dac_code` never changes by more than one LSB per clock while enabled.
- R4: `clk_en_n` goes low at the second rising edge, counting the edge that samples the `WIN_N`-th consecutive strobe (`pwm_stb` = 1) taken with `in_window` = 1.
- R5: A strobe sampled with `in_window` = 0 restarts the consecutive count from zero.
- R6: With `gpu_mode` = 0, once `clk_en_n` is low, `dac_code` moves one LSB per `TICK_CYC` cycles to `vid_code`.
- R7: With `gpu_mode` = 1, the first stage ramps one LSB per `TICK_CYC` cycles directly to `vid_code`, with no boot stage.
- R8: After locking, a lower `vid_code` makes `dac_code` step down one LSB per `TICK_CYC` cycles until it matches.
- R9: `pgood` rises `PG_DLY + 1` edges after the edge at which the ramp stage is entered, provided `clk_en_n` is already low by then.
- R10: `pgood` is never high while `clk_en_n` is high. If lock comes after the power-good delay, `pgood` rises one edge after `clk_en_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Start request |
| por_ok | input | 1 | Supply above power-on-reset threshold |
| gpu_mode | input | 1 | 1: direct ramp to VID; 0: boot stage first |
| vid_code | input | DAC_W | Commanded DAC code, 5 mV per LSB |
| pwm_stb | input | 1 | One-cycle pulse per PWM period |
| in_window | input | 1 | Output inside regulation band |
| dac_code | output | DAC_W | Reference DAC code |
| clk_en_n | output | 1 | Active-low clock enable |
| pgood | output | 1 | Power good |

## Verification
Several properties are checked on every cycle: the return to idle after enable or POR is lost, the limit of one LSB per clock on the DAC code, and that power-good never rises without the clock enable being low. The exact slew periods, the start-delay offset, the restart of the window count after a miss, the two-edge lock latency and the power-good timing cannot be seen by a cycle-local property. The bench shows them by comparing each DAC code change and its spacing against a queue of expected steps, and by sampling lock and power-good at computed cycles in CPU and GPU runs.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DELAY  = 2'd1,
      ST_STAGE1 = 2'd2,
      ST_LOCKED = 2'd3
   } seq_state_t;
endpackage

// File: rtl/vrs_tick_gen.sv
module vrs_tick_gen #(
   parameter int TICK_CYC = 100,
   parameter int SLOW_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic fast_tick,
   output logic slow_tick
);
   localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        tcnt <= '0;
      else if (!run)                     tcnt <= '0;
      else if (tcnt == TW'(TICK_CYC-1))  tcnt <= '0;
      else                               tcnt <= tcnt + 1'b1;
   end

   assign fast_tick = run && (tcnt == TW'(TICK_CYC-1));

   generate
      if (SLOW_DIV == 1) begin : g_same
         assign slow_tick = fast_tick;
      end else begin : g_div
         localparam int HW = $clog2(SLOW_DIV);
         logic [HW-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hcnt <= '0;
            else if (!run)  hcnt <= '0;
            else if (fast_tick)
               hcnt <= (hcnt == HW'(SLOW_DIV-1)) ? '0 : hcnt + 1'b1;
         end
         assign slow_tick = fast_tick && (hcnt == HW'(SLOW_DIV-1));
      end
   endgenerate
endmodule

// File: rtl/vrs_win_count.sv
module vrs_win_count #(
   parameter int WIN_N = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic stb,
   input  logic inwin,
   output logic done
);
   localparam int CW = $clog2(WIN_N + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!enable) cnt <= '0;
      else if (stb) begin
         if (!inwin)                     cnt <= '0;
         else if (cnt != CW'(WIN_N))     cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == CW'(WIN_N));
endmodule

// File: rtl/vrs_dac_ramp.sv
module vrs_dac_ramp #(
   parameter int DAC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [DAC_W-1:0] target,
   output logic [DAC_W-1:0] code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       code <= '0;
      else if (clr)                     code <= '0;
      else if (step && code < target)   code <= code + 1'b1;
      else if (step && code > target)   code <= code - 1'b1;
   end
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq
   import vrs_pkg::*;
#(
   parameter int DAC_W     = 8,
   parameter int BOOT_CODE = 220,
   parameter int TICK_CYC  = 100,
   parameter int SLOW_DIV  = 2,
   parameter int START_DLY = 12000,
   parameter int PG_DLY    = 700000,
   parameter int WIN_N     = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_req,
   input  logic             por_ok,
   input  logic             gpu_mode,
   input  logic [DAC_W-1:0] vid_code,
   input  logic             pwm_stb,
   input  logic             in_window,
   output logic [DAC_W-1:0] dac_code,
   output logic             clk_en_n,
   output logic             pgood
);
   localparam int DW = (START_DLY > 1) ? $clog2(START_DLY) : 1;
   localparam int PW = $clog2(PG_DLY + 1);

   if (DAC_W < 2 || DAC_W > 16) begin : g_bad_w
      $error("DAC_W out of range");
   end
   if (BOOT_CODE < 1 || BOOT_CODE >= (1 << DAC_W)) begin : g_bad_boot
      $error("BOOT_CODE does not fit DAC_W");
   end
   if (TICK_CYC < 2 || SLOW_DIV < 1 || START_DLY < 1 || PG_DLY < 1 || WIN_N < 1) begin : g_bad_t
      $error("timing parameter out of range");
   end

   seq_state_t       state;
   logic [DW-1:0]    dcnt;
   logic [PW-1:0]    pgc;
   logic             go, run, fast_tick, slow_tick, win_done, step;
   logic [DAC_W-1:0] target;

   assign go  = en_req && por_ok;
   assign run = (state == ST_STAGE1) || (state == ST_LOCKED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !go) begin
         state    <= ST_IDLE;
         dcnt     <= '0;
         clk_en_n <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               state <= ST_DELAY;
               dcnt  <= '0;
            end
            ST_DELAY: begin
               if (dcnt == DW'(START_DLY-1)) state <= ST_STAGE1;
               else                          dcnt  <= dcnt + 1'b1;
            end
            ST_STAGE1: begin
               if (win_done) begin
                  state    <= ST_LOCKED;
                  clk_en_n <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !go) begin
         pgc   <= '0;
         pgood <= 1'b0;
      end else begin
         if (run && pgc != PW'(PG_DLY)) pgc <= pgc + 1'b1;
         pgood <= (state == ST_LOCKED) && (pgc == PW'(PG_DLY));
      end
   end

   always_comb begin
      if (state == ST_STAGE1 && !gpu_mode) begin
         target = DAC_W'(BOOT_CODE);
         step   = slow_tick;
      end else begin
         target = vid_code;
         step   = fast_tick;
      end
   end

   vrs_tick_gen #(.TICK_CYC(TICK_CYC), .SLOW_DIV(SLOW_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run),
      .fast_tick(fast_tick), .slow_tick(slow_tick)
   );

   vrs_win_count #(.WIN_N(WIN_N)) u_win (
      .clk(clk), .rst_n(rst_n), .enable(state == ST_STAGE1),
      .stb(pwm_stb), .inwin(in_window), .done(win_done)
   );

   vrs_dac_ramp #(.DAC_W(DAC_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .clr(!go), .step(step),
      .target(target), .code(dac_code)
   );
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
   parameter int DAC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_req,
   input logic             por_ok,
   input logic [DAC_W-1:0] dac_code,
   input logic             clk_en_n,
   input logic             pgood
);
   a_r1_idle_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_req && por_ok) |=> (dac_code == '0) && clk_en_n && !pgood);

   a_r3_one_lsb_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (en_req && por_ok) |=> ((dac_code == $past(dac_code)) ||
                              (dac_code == $past(dac_code) + 1'b1) ||
                              ($past(dac_code) == dac_code + 1'b1)));

   a_r10_pgood_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> !clk_en_n);

   a_r10_pgood_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> !$past(clk_en_n));

   a_r4_lock_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_n) |-> $past(en_req && por_ok));
endmodule

bind vr_startup_seq vrs_checker #(.DAC_W(DAC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_req(en_req), .por_ok(por_ok),
   .dac_code(dac_code), .clk_en_n(clk_en_n), .pgood(pgood)
);

// File: tb/test_vr_startup_seq.sv
`timescale 1ns/1ps
module test_vr_startup_seq;
   localparam int DW = 8, BOOT = 20, T = 4, SD = 10, PGD = 300, WN = 13;

   typedef struct {
      int    code;
      int    gap;
      string req;
   } exp_t;

   logic          clk = 0, rst_n = 0, en_req = 0, por_ok = 0, gpu_mode = 0;
   logic [DW-1:0] vid_code = '0;
   logic          pwm_stb = 0, in_window = 0;
   logic [DW-1:0] dac_code;
   logic          clk_en_n, pgood;

   int   checks = 0, fails = 0, cyc = 0, ref_t = 0, t0 = 0, s0 = 0;
   int   prev = 0;
   exp_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vr_startup_seq #(.DAC_W(DW), .BOOT_CODE(BOOT), .TICK_CYC(T), .SLOW_DIV(2),
                    .START_DLY(SD), .PG_DLY(PGD), .WIN_N(WN)) i_vr_startup_seq (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .por_ok(por_ok),
      .gpu_mode(gpu_mode), .vid_code(vid_code), .pwm_stb(pwm_stb),
      .in_window(in_window), .dac_code(dac_code), .clk_en_n(clk_en_n),
      .pgood(pgood)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input int code, input int gap, input string req);
      exp_t e;
      e.code = code; e.gap = gap; e.req = req;
      q.push_back(e);
   endtask

   task automatic strobes(input int n, input bit w);
      for (int i = 0; i < n; i++) begin
         repeat (15) @(negedge clk);
         pwm_stb = 1; in_window = w;
         @(negedge clk);
         pwm_stb = 0;
      end
   endtask

   // scoreboard monitor: every DAC change must match the next queued step
   always @(negedge clk) begin
      if (rst_n && int'(dac_code) != prev) begin
         if (q.size() == 0) begin
            chk(0, "R3 unexpected step", int'(dac_code), prev);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(int'(dac_code) == e.code, e.req, int'(dac_code), e.code);
            if (e.gap != 0) chk(cyc - ref_t == e.gap, {e.req, " spacing"}, cyc - ref_t, e.gap);
         end
         ref_t = cyc;
      end
      prev = int'(dac_code);
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(dac_code == 0 && clk_en_n && !pgood, "R1 reset state", int'(dac_code), 0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // CPU mode
      gpu_mode = 0; vid_code = 30;
      push(1, SD + 2*T + 1, "R2 cpu first step");
      for (int c = 2; c <= BOOT; c++) push(c, 2*T, "R3 boot ramp");
      @(negedge clk);
      en_req = 1; por_ok = 1; t0 = cyc; ref_t = cyc;
      strobes(12, 1);
      chk(dac_code == BOOT, "R3 holds boot code", int'(dac_code), BOOT);
      strobes(1, 0);
      strobes(5, 1);
      chk(clk_en_n == 1, "R5 miss restarts count", clk_en_n, 1);
      push(21, 0, "R6 stage two");
      for (int c = 22; c <= 30; c++) push(c, T, "R6 stage two");
      strobes(7, 1);
      repeat (15) @(negedge clk);
      pwm_stb = 1; in_window = 1;
      @(negedge clk);
      pwm_stb = 0;
      chk(clk_en_n == 1, "R4 not yet locked", clk_en_n, 1);
      chk(pgood == 0, "R10 pgood waits for lock", pgood, 0);
      @(negedge clk);
      chk(clk_en_n == 0, "R4 locked", clk_en_n, 0);
      chk(pgood == 0, "R10 pgood after lock", pgood, 0);
      @(negedge clk);
      chk(pgood == 1, "R10 pgood follows late lock", pgood, 1);
      repeat (60) @(negedge clk);
      chk(dac_code == 30, "R6 reaches vid", int'(dac_code), 30);
      push(29, 0, "R8 step down");
      for (int c = 28; c >= 25; c--) push(c, T, "R8 step down");
      vid_code = 25;
      repeat (40) @(negedge clk);
      chk(dac_code == 25, "R8 settles", int'(dac_code), 25);
      push(0, 0, "R1 abort");
      en_req = 0;
      @(negedge clk);
      chk(dac_code == 0 && clk_en_n && !pgood, "R1 enable drop", int'(dac_code), 0);
      repeat (20) @(negedge clk);
      chk(dac_code == 0 && clk_en_n && !pgood, "R1 stays idle", int'(dac_code), 0);

      // GPU mode
      gpu_mode = 1; vid_code = 12;
      push(1, SD + T + 1, "R2 gpu first step");
      for (int c = 2; c <= 12; c++) push(c, T, "R7 direct ramp");
      @(negedge clk);
      en_req = 1; t0 = cyc; ref_t = cyc; s0 = t0 + 1 + SD;
      strobes(13, 1);
      @(negedge clk);
      chk(clk_en_n == 0, "R4 gpu lock", clk_en_n, 0);
      chk(dac_code == 12, "R7 reached vid", int'(dac_code), 12);
      while (cyc < s0 + PGD) @(negedge clk);
      chk(pgood == 0, "R9 before delay", pgood, 0);
      @(negedge clk);
      chk(pgood == 1, "R9 after delay", pgood, 1);
      push(0, 0, "R1 por loss");
      por_ok = 0;
      @(negedge clk);
      chk(dac_code == 0 && clk_en_n && !pgood, "R1 por loss", int'(dac_code), 0);
      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R3 all steps seen", q.size(), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule